// File: doc/BRIEF.md
# UART receive FIFO with interrupts

This block sits between a UART deserializer and a register-mapped host port. Each character the deserializer delivers is stored with its break, parity-error and frame-error flags in a 16-entry first-in first-out buffer. The host drains the buffer through a data port and watches three receive interrupt sources: FIFO overrun, fill level above a programmable threshold, and an idle timeout measured in character times.

The host side is a simple strobe interface with a two-bit address. Address 0 is the data port, and a read there pops one entry. Address 1 is the interrupt register, holding masks, status and a not-empty flag. Address 2 is the control register, holding the threshold, the timeout count and a self-clearing FIFO reset bit. A bit-time tick from the baud generator drives the timeout. One character time is `BITS_PER_CHAR` ticks (default 10).

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset the FIFO is empty, `irq_o` is 0, the interrupt register reads 0, and the control register reads 0x108 (threshold 8, timeout 1).
- R2: A read at address 0 pops the oldest entry and returns data in [7:0], valid in bit 8, break in bit 9, parity error in bit 10 and frame error in bit 11, with all other bits 0. Entries come out in arrival order. A read of an empty FIFO returns 0 and changes nothing.
- R3: The FIFO holds 16 entries. A character that arrives while the FIFO is full (with no pop in the same cycle) is discarded, the stored entries are kept, and overrun status (interrupt register bit 4) is set.
- R4: Overrun status is not cleared by reads. Only a write to address 2 with bit 16 set clears it, and that write also empties the FIFO in one cycle.
- R5: Threshold status (bit 5) is 1 exactly while the fill level is greater than the threshold field, control bits [3:0].
- R6: Timeout status (bit 6) sets once the FIFO has been non-empty for (control bits [11:8]) × `BITS_PER_CHAR` ticks with no push or pop. A push or pop restarts the count. The status holds until a pop or a FIFO reset. A timeout field of 0 disables it.
- R7: Interrupt register bit 7 is 1 exactly while the FIFO is non-empty.
- R8: A write to address 1 loads only the masks in bits [2:0] (overrun, threshold, timeout) and leaves all status bits unchanged.
- R9: `irq_o` is the OR over the three sources of status AND mask.
- R10: The control register reads back the threshold in [3:0] and the timeout in [11:8]. Bit 16 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_vld_i | input | 1 | Character-valid strobe from deserializer |
| char_data_i | input | 8 | Received character |
| char_brk_i | input | 1 | Break detected for this character |
| char_par_i | input | 1 | Parity error for this character |
| char_frm_i | input | 1 | Frame error for this character |
| tick_i | input | 1 | One-cycle pulse per bit time |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops at address 0) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Receive interrupt |

## Verification
Read data is combinational from the address and the head entry. The bench samples it one nanosecond after driving a read at the falling edge, and the pop takes effect at the following rising edge. Every status bit and `irq_o` reflects a push, pop, write or tick at the next rising edge. Checks therefore sample at the falling edge after the stimulus cycle. For the timeout, the bench counts ticks exactly: it checks that the status is still clear after one tick fewer than the limit and set after the last tick. It also checks that a push in the middle of the window restarts the count.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int CHAR_W = 8;
  localparam int REG_W  = 32;

  typedef struct packed {
    logic              frm;
    logic              par;
    logic              brk;
    logic [CHAR_W-1:0] data;
  } rx_ent_t;

  // interrupt source order: mask bit i, status bit i+STAT_LSB
  localparam int SRC_OVR  = 0;
  localparam int SRC_THR  = 1;
  localparam int SRC_TMO  = 2;
  localparam int NSRC     = 3;
  localparam int STAT_LSB = 4;
  localparam int NEMPTY_B = 7;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_IRQ  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_TMO_LSB = 8;
  localparam int CTRL_RST_B   = 16;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  rx_ent_t       ent_i,
  input  logic          pop_i,
  output rx_ent_t       ent_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovr_evt_o
);
  rx_ent_t       mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  assign level_o = level_q;
  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign ent_o   = mem[rptr_q];

  always_comb begin
    do_pop    = pop_i && !empty_o && !flush_i;
    do_push   = push_i && (!full_o || do_pop) && !flush_i;
    ovr_evt_o = push_i && full_o && !do_pop && !flush_i;
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= ent_i;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  assert_drop_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && $stable(rptr_q)));
  assert_flush_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter  int BITS_PER_CHAR = 10,
  parameter  int TMO_W         = 4,
  localparam int BW            = $clog2(BITS_PER_CHAR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             fire_o
);
  logic [BW-1:0]    bt_q;
  logic [TMO_W-1:0] ch_q;
  logic             bt_end, hit;

  assign bt_end = (bt_q == BW'(BITS_PER_CHAR - 1));
  assign hit    = tick_i && !restart_i && bt_end && (limit_i != '0) &&
                  (({1'b0, ch_q} + 1'b1) == {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bt_q <= '0;
      ch_q <= '0;
    end else if (restart_i) begin
      bt_q <= '0;
      ch_q <= '0;
    end else if (tick_i) begin
      if (bt_end) begin
        bt_q <= '0;
        if (ch_q != '1) ch_q <= ch_q + 1'b1;
      end else begin
        bt_q <= bt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fire_o <= 1'b0;
    else if (clr_i)  fire_o <= 1'b0;
    else if (hit)    fire_o <= 1'b1;
  end

  assert_tmo_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fire_o);
  assert_tmo_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i == '0 && !fire_o) |=> !fire_o);
endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl
  import uart_rxq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            ovr_evt_i,
  input  logic            thr_lvl_i,
  input  logic            tmo_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] stat_o,
  output logic            irq_o
);
  logic [NSRC-1:0] mask_q;
  logic            ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  // overrun is sticky; only the FIFO reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (flush_i)   ovr_q <= 1'b0;
    else if (ovr_evt_i) ovr_q <= 1'b1;
  end

  always_comb begin
    stat_o          = '0;
    stat_o[SRC_OVR] = ovr_q;
    stat_o[SRC_THR] = thr_lvl_i;
    stat_o[SRC_TMO] = tmo_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(stat_o & mask_q);

  assert_ovr_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !flush_i) |=> ovr_q);
  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import uart_rxq_pkg::*;
#(
  parameter  int DEPTH         = 16,
  parameter  int BITS_PER_CHAR = 10,
  parameter  int TMO_W         = 4,
  localparam int THR_W         = $clog2(DEPTH / 2) + 1,
  localparam int LW            = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_vld_i,
  input  logic [CHAR_W-1:0] char_data_i,
  input  logic              char_brk_i,
  input  logic              char_par_i,
  input  logic              char_frm_i,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [THR_W-1:0] thr_q;
  logic [TMO_W-1:0] tmo_q;
  logic             flush, pop, ctrl_we;
  rx_ent_t          ent_in, ent_out;
  logic [LW-1:0]    level;
  logic             full, empty, ovr_evt, tmo_stat;
  logic [NSRC-1:0]  mask, stat;
  logic             unused_wdata;

  assign ctrl_we = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign flush   = ctrl_we && reg_wdata_i[CTRL_RST_B];
  assign pop     = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign ent_in  = '{frm: char_frm_i, par: char_par_i, brk: char_brk_i, data: char_data_i};
  assign unused_wdata = ^{reg_wdata_i[REG_W-1:CTRL_RST_B+1],
                          reg_wdata_i[CTRL_RST_B-1:CTRL_TMO_LSB+TMO_W],
                          reg_wdata_i[CTRL_TMO_LSB-1:THR_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= THR_W'(DEPTH / 2);
      tmo_q <= TMO_W'(1);
    end else if (ctrl_we) begin
      thr_q <= reg_wdata_i[THR_W-1:0];
      tmo_q <= reg_wdata_i[CTRL_TMO_LSB +: TMO_W];
    end
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .flush_i  (flush),
    .push_i   (char_vld_i),
    .ent_i    (ent_in),
    .pop_i    (pop),
    .ent_o    (ent_out),
    .level_o  (level),
    .full_o   (full),
    .empty_o  (empty),
    .ovr_evt_o(ovr_evt)
  );

  rxq_idle_timer #(.BITS_PER_CHAR(BITS_PER_CHAR), .TMO_W(TMO_W)) u_timer (
    .clk_i, .rst_ni,
    .restart_i(char_vld_i || pop || flush || empty),
    .clr_i    ((pop && !empty) || flush),
    .tick_i,
    .limit_i  (tmo_q),
    .fire_o   (tmo_stat)
  );

  rxq_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .flush_i  (flush),
    .ovr_evt_i(ovr_evt),
    .thr_lvl_i(level > LW'(thr_q)),
    .tmo_i    (tmo_stat),
    .mask_we_i(reg_wr_i && (reg_addr_i == ADDR_IRQ)),
    .mask_i   (reg_wdata_i[NSRC-1:0]),
    .mask_o   (mask),
    .stat_o   (stat),
    .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_DATA: if (!empty)
        reg_rdata_o[CHAR_W+3:0] = {ent_out.frm, ent_out.par, ent_out.brk, 1'b1, ent_out.data};
      ADDR_IRQ: begin
        reg_rdata_o[NSRC-1:0]                = mask;
        reg_rdata_o[STAT_LSB +: NSRC]        = stat;
        reg_rdata_o[NEMPTY_B]                = !empty;
      end
      ADDR_CTRL: begin
        reg_rdata_o[THR_W-1:0]               = thr_q;
        reg_rdata_o[CTRL_TMO_LSB +: TMO_W]   = tmo_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assert_full_sets_ovr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_i && full && !pop && !flush) |=> stat[SRC_OVR]);
  assert_thr_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !stat[SRC_THR]);
endmodule

// File: tb/sim_uart_rx_fifo_irq.sv
module sim_uart_rx_fifo_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        char_vld_i = 1'b0;
  logic [7:0]  char_data_i = '0;
  logic        char_brk_i = 1'b0, char_par_i = 1'b0, char_frm_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  always #4 clk_i = ~clk_i;

  uart_rx_fifo_irq u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one character per cycle, expected word queued when it fits
  task automatic send(logic [7:0] d, logic brk, logic par, logic frm);
    char_vld_i = 1; char_data_i = d; char_brk_i = brk; char_par_i = par; char_frm_i = frm;
    if (exp_q.size() < 16) exp_q.push_back({20'b0, frm, par, brk, 1'b1, d});
    @(negedge clk_i);
    char_vld_i = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  // monitor: pop from the design, compare with the queue head
  task automatic rd_data(string req);
    logic [31:0] exp;
    exp = (exp_q.size() != 0) ? exp_q.pop_front() : 32'h0;
    reg_rd_i = 1; reg_addr_i = 2'd0;
    #1 chk(req, reg_rdata_o, exp);
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; @(negedge clk_i);
    end
    tick_i = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    peek(2'd1, v); chk("R1 irq reg", v, 32'h0);
    peek(2'd2, v); chk("R1 ctrl", v, 32'h108);
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    peek(2'd0, v); chk("R1 empty data", v, 32'h0);

    // R2 format and order, R7 not-empty
    send(8'hA5, 0, 0, 0);
    send(8'h3C, 1, 0, 0);
    send(8'h01, 0, 1, 1);
    peek(2'd1, v); chk("R7 not-empty", v, 32'h80);
    rd_data("R2 entry0");
    rd_data("R2 entry1 brk");
    rd_data("R2 entry2 par frm");
    rd_data("R2 empty read");
    peek(2'd1, v); chk("R7 empty again", v, 32'h0);

    // R5 threshold, R8 mask-only write, R9 irq
    wr(2'd2, 32'h102);
    peek(2'd2, v); chk("R10 ctrl readback", v, 32'h102);
    send(8'h10, 0, 0, 0);
    send(8'h11, 0, 0, 0);
    peek(2'd1, v); chk("R5 level 2 not above", v, 32'h80);
    send(8'h12, 0, 0, 0);
    peek(2'd1, v); chk("R5 level 3 above", v, 32'hA0);
    chk("R9 unmasked irq low", {31'b0, irq_o}, 32'h0);
    wr(2'd1, 32'hFFFF_FFF2);
    peek(2'd1, v); chk("R8 only masks loaded", v, 32'hA2);
    chk("R9 irq on thr", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h0);
    peek(2'd1, v); chk("R8 status kept", v, 32'hA0);
    chk("R9 irq masked off", {31'b0, irq_o}, 32'h0);
    repeat (3) rd_data("R2 drain thr");

    // R6 timeout: limit 2 char times = 20 ticks
    wr(2'd2, 32'h202);
    wr(2'd1, 32'h4);
    send(8'h20, 0, 0, 0);
    ticks(19);
    peek(2'd1, v); chk("R6 not yet", v, 32'h84);
    ticks(1);
    peek(2'd1, v); chk("R6 fired", v, 32'hC4);
    chk("R9 irq on tmo", {31'b0, irq_o}, 32'h1);
    send(8'h21, 0, 0, 0);
    peek(2'd1, v); chk("R6 held across push", v, 32'hC4);
    rd_data("R6 pop clears");
    peek(2'd1, v); chk("R6 cleared by read", v, 32'h84);
    ticks(15);
    send(8'h22, 0, 0, 0);
    ticks(15);
    peek(2'd1, v); chk("R6 push restarts", v, 32'h84);
    ticks(5);
    peek(2'd1, v); chk("R6 fires after restart", v, 32'hC4);
    repeat (2) rd_data("R2 drain tmo");
    wr(2'd2, 32'h002);
    send(8'h23, 0, 0, 0);
    ticks(40);
    peek(2'd1, v); chk("R6 disabled at 0", v, 32'h84);
    rd_data("R2 drain tmo0");

    // R3 overrun, R4 sticky and reset
    wr(2'd2, 32'h008);
    wr(2'd1, 32'h1);
    for (int i = 0; i < 17; i++) send(8'h40 + 8'(i), 0, 0, 0);
    peek(2'd1, v); chk("R3 overrun set", v, 32'hB1);
    chk("R9 irq on ovr", {31'b0, irq_o}, 32'h1);
    for (int i = 0; i < 16; i++) rd_data("R3 contents kept");
    rd_data("R3 extra discarded");
    peek(2'd1, v); chk("R4 overrun survives reads", v, 32'h11);
    send(8'h55, 0, 0, 0);
    send(8'h56, 0, 0, 0);
    wr(2'd2, 32'h1_0008);
    exp_q.delete();
    peek(2'd1, v); chk("R4 reset clears ovr and empties", v, 32'h1);
    chk("R4 irq low after reset", {31'b0, irq_o}, 32'h0);
    peek(2'd0, v); chk("R4 data empty", v, 32'h0);
    peek(2'd2, v); chk("R10 reset bit reads 0", v, 32'h008);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule